// File: doc/BRIEF.md
# Serial Register Access Port with Latch-Pulse Mode Entry

This block is a four-wire serial slave that turns framed transfers into accesses on a simple parallel register bus. Out of reset it does not respond on the serial wires. It starts responding only after the active-low select line has gone low and come back high three times. From then on, every select-low window is one transfer. The first byte names the target device and the direction. The next two bytes give a 16-bit location. The bytes after that are data, and a transfer may run over as many consecutive locations as the host wants.

All serial inputs are sampled by a system clock that must run at least four times faster than the serial clock, through two-stage synchronizers. Serial-clock and select edges are found in the system clock domain. Writes come out as one-cycle strobes, one per complete location of `BYTES_PER_LOC` bytes. Reads issue a one-cycle strobe as soon as the location is known, and then again after each location has been shifted out, so the next word is fetched before it is needed. The serial output has a separate enable, and that enable is high only while read data is being returned.

Top module: `spi_regport`

## Requirements
- R1: After reset, `sdo_oe_o`, `reg_wr_o` and `reg_rd_o` are low. A transfer made before the mode has been entered gives no strobe and no output drive.
- R2: The port starts decoding transfers only once the third low pulse of `sel_n_i` has ended. A transfer whose own select-low window is the third pulse is still ignored. Once entered, the mode holds until reset.
- R3: Serial input is sampled on the rising edge of `sck_i` and is MSB first. In byte 0, bits 7:1 hold the device address and bit 0 gives the direction (1 = read, 0 = write).
- R4: The device address must equal 7'b0000000 when `addr_pin_i` is low, or 7'b0000001 when it is high. With any other address the transfer gives no strobe and no output drive.
- R5: Bytes 1 and 2 form the 16-bit location, high byte first, and it appears on `reg_addr_o`.
- R6: In a write, each complete group of `BYTES_PER_LOC` data bytes gives exactly one one-cycle `reg_wr_o` pulse. The first byte of the group is the most significant byte of `reg_wdata_o`.
- R7: In a burst, the location goes up by one for each complete location, with a full 16-bit carry (0x00FF is followed by 0x0100). This holds for both reads and writes.
- R8: In a read, `reg_rd_o` pulses one system cycle after the last bit of byte 2, with the location on `reg_addr_o`. It pulses again after each complete location, with the next location. `reg_rdata_i` is sampled in the cycle of the pulse.
- R9: Read data changes after falling edges of `sck_i`, MSB first. `sdo_oe_o` rises at the falling edge that ends byte 2, so the first data bit is valid for the first rising edge of byte 3.
- R10: `sdo_oe_o` is low during bytes 0 to 2, during writes, and after `sel_n_i` goes high.
- R11: If `sel_n_i` goes high partway through a location, the transfer ends, the partial data is dropped without a strobe, and the output returns to high-Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n_i | input | 1 | Active-low select / latch line |
| sck_i | input | 1 | Serial clock, idles low |
| sdi_i | input | 1 | Serial data in |
| addr_pin_i | input | 1 | Device address select pin |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for `sdo_o`; low means high-Z |
| reg_addr_o | output | 16 | Register bus location |
| reg_wdata_o | output | 8*BYTES_PER_LOC | Register bus write data |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_rd_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 8*BYTES_PER_LOC | Read data, valid in the strobe cycle |

## Verification
The assertions assume that each edge of `sck_i` and `sel_n_i` is separated from the next by several system cycles. Under that assumption a strobe, its address increment and the next output shift never land in the same cycle. They also assume that `sel_n_i` never changes within a few cycles of an `sck_i` edge. The bench meets both conditions by driving every input on a falling system-clock edge and holding each serial half-period for six system cycles. It also keeps the select setup and hold at six cycles or more.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    typedef enum logic [1:0] {
        PH_DEV  = 2'd0,
        PH_SUBH = 2'd1,
        PH_SUBL = 2'd2,
        PH_DATA = 2'd3
    } phase_e;

    localparam int SUB_W = 16;

endpackage

// File: rtl/spi_rp_sync.sv
module spi_rp_sync #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d      = sy_q;
        sy_d.meta = raw_i;
        sy_d.stab = sy_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '{meta: RST_VAL, stab: RST_VAL};
        else        sy_q <= sy_d;
    end

    assign lvl_o = sy_q.stab;
endmodule

// File: rtl/spi_rp_mode.sv
module spi_rp_mode #(
    parameter int PULSES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_lvl_i,
    output logic mode_o
);
    localparam int CW = $clog2(PULSES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sel_p;
    } mode_t;

    mode_t md_d, md_q;
    logic  sel_rise;

    assign sel_rise = sel_lvl_i & ~md_q.sel_p;
    assign mode_o   = (md_q.cnt == CW'(PULSES));

    always_comb begin
        md_d       = md_q;
        md_d.sel_p = sel_lvl_i;
        if (!mode_o && sel_rise) md_d.cnt = md_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) md_q <= '{cnt: '0, sel_p: 1'b1};
        else        md_q <= md_d;
    end

    // R2: once entered, the mode never drops
    a_r2_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o |=> mode_o);
    // R2: entry happens only at the end of a low pulse
    a_r2_entry_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_o) |-> $past(sel_rise));
endmodule

// File: rtl/spi_rp_engine.sv
module spi_rp_engine
    import spi_regport_pkg::*;
#(
    parameter int BYTES_PER_LOC = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mode_i,
    input  logic                       sel_lvl_i,
    input  logic                       sck_lvl_i,
    input  logic                       sdi_lvl_i,
    input  logic                       addr_pin_i,
    input  logic [8*BYTES_PER_LOC-1:0] rdata_i,
    output logic [SUB_W-1:0]           addr_o,
    output logic [8*BYTES_PER_LOC-1:0] wdata_o,
    output logic                       wr_o,
    output logic                       rd_o,
    output logic                       sdo_o,
    output logic                       oe_o
);
    localparam int DW   = 8 * BYTES_PER_LOC;
    localparam int LB_W = (BYTES_PER_LOC > 1) ? $clog2(BYTES_PER_LOC) : 1;

    typedef struct packed {
        logic             sel_p;
        logic             sck_p;
        logic             active;
        logic [2:0]       bit_n;
        phase_e           ph;
        logic [6:0]       sh;
        logic             match;
        logic             rd_mode;
        logic [LB_W-1:0]  locb;
        logic [SUB_W-1:0] addr;
        logic [DW-1:0]    wacc;
        logic [DW-1:0]    wdata;
        logic             wr;
        logic             rd;
        logic [DW-1:0]    obuf;
        logic             sdo;
        logic             oe;
    } eng_t;

    eng_t eg_d, eg_q;
    logic sel_rise, sel_fall, sck_rise, sck_fall;
    logic [7:0] byte_v;

    assign sel_rise = sel_lvl_i & ~eg_q.sel_p;
    assign sel_fall = ~sel_lvl_i & eg_q.sel_p;
    assign sck_rise = sck_lvl_i & ~eg_q.sck_p;
    assign sck_fall = ~sck_lvl_i & eg_q.sck_p;
    assign byte_v   = {eg_q.sh, sdi_lvl_i};

    always_comb begin
        eg_d       = eg_q;
        eg_d.sel_p = sel_lvl_i;
        eg_d.sck_p = sck_lvl_i;
        eg_d.wr    = 1'b0;
        eg_d.rd    = 1'b0;
        if (eg_q.wr) eg_d.addr = eg_q.addr + 1'b1;
        if (eg_q.rd) eg_d.obuf = rdata_i;

        if (sel_rise) begin
            eg_d.active = 1'b0;
            eg_d.oe     = 1'b0;
            eg_d.sdo    = 1'b0;
        end else if (sel_fall && mode_i) begin
            eg_d.active  = 1'b1;
            eg_d.bit_n   = '0;
            eg_d.ph      = PH_DEV;
            eg_d.locb    = '0;
            eg_d.match   = 1'b0;
            eg_d.rd_mode = 1'b0;
            eg_d.wacc    = '0;
        end else if (eg_q.active) begin
            if (sck_rise) begin
                eg_d.sh    = byte_v[6:0];
                eg_d.bit_n = eg_q.bit_n + 1'b1;
                if (eg_q.bit_n == 3'd7) begin
                    case (eg_q.ph)
                        PH_DEV: begin
                            eg_d.match   = (byte_v[7:1] == {6'd0, addr_pin_i});
                            eg_d.rd_mode = byte_v[0];
                            eg_d.ph      = PH_SUBH;
                        end
                        PH_SUBH: begin
                            if (eg_q.match) eg_d.addr[15:8] = byte_v;
                            eg_d.ph = PH_SUBL;
                        end
                        PH_SUBL: begin
                            if (eg_q.match) eg_d.addr[7:0] = byte_v;
                            eg_d.ph = PH_DATA;
                            eg_d.rd = eg_q.match & eg_q.rd_mode;
                        end
                        default: begin
                            if (eg_q.match) begin
                                eg_d.wacc = (eg_q.wacc << 8) | DW'(byte_v);
                                if (eg_q.locb == LB_W'(BYTES_PER_LOC - 1)) begin
                                    eg_d.locb = '0;
                                    if (eg_q.rd_mode) begin
                                        eg_d.addr = eg_q.addr + 1'b1;
                                        eg_d.rd   = 1'b1;
                                    end else begin
                                        eg_d.wr    = 1'b1;
                                        eg_d.wdata = (eg_q.wacc << 8) | DW'(byte_v);
                                    end
                                end else begin
                                    eg_d.locb = eg_q.locb + 1'b1;
                                end
                            end
                        end
                    endcase
                end
            end
            if (sck_fall && eg_q.match && eg_q.rd_mode && eg_q.ph == PH_DATA) begin
                eg_d.oe   = 1'b1;
                eg_d.sdo  = eg_q.obuf[DW-1];
                eg_d.obuf = eg_q.obuf << 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eg_q       <= '0;
            eg_q.sel_p <= 1'b1;
            eg_q.ph    <= PH_DEV;
        end else begin
            eg_q <= eg_d;
        end
    end

    assign addr_o  = eg_q.addr;
    assign wdata_o = eg_q.wdata;
    assign wr_o    = eg_q.wr;
    assign rd_o    = eg_q.rd;
    assign sdo_o   = eg_q.sdo;
    assign oe_o    = eg_q.oe;

    // R6: a write strobe lasts one cycle
    a_r6_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        eg_q.wr |=> !eg_q.wr);
    // R7: location advances by one after each write strobe
    a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        eg_q.wr |=> (eg_q.addr == $past(eg_q.addr) + 16'd1));
    // R8: read and write strobes never coincide
    a_r8_rd_wr_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(eg_q.wr && eg_q.rd));
    // R9: drive starts only on a serial falling edge
    a_r9_oe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eg_q.oe) |-> $past(sck_fall));
    // R10: select high releases the output
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        sel_rise |=> !eg_q.oe);
    // R1: no drive before the mode is entered
    a_r1_oe_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        eg_q.oe |-> mode_i);
endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int BYTES_PER_LOC = 2,
    parameter int MODE_PULSES   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sel_n_i,
    input  logic                       sck_i,
    input  logic                       sdi_i,
    input  logic                       addr_pin_i,
    output logic                       sdo_o,
    output logic                       sdo_oe_o,
    output logic [SUB_W-1:0]           reg_addr_o,
    output logic [8*BYTES_PER_LOC-1:0] reg_wdata_o,
    output logic                       reg_wr_o,
    output logic                       reg_rd_o,
    input  logic [8*BYTES_PER_LOC-1:0] reg_rdata_i
);
    logic [2:0] lvl;
    logic       mode;

    spi_rp_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({sdi_i, sck_i, sel_n_i}),
        .lvl_o (lvl)
    );

    spi_rp_mode #(.PULSES(MODE_PULSES)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_lvl_i (lvl[0]),
        .mode_o    (mode)
    );

    spi_rp_engine #(.BYTES_PER_LOC(BYTES_PER_LOC)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .sel_lvl_i  (lvl[0]),
        .sck_lvl_i  (lvl[1]),
        .sdi_lvl_i  (lvl[2]),
        .addr_pin_i (addr_pin_i),
        .rdata_i    (reg_rdata_i),
        .addr_o     (reg_addr_o),
        .wdata_o    (reg_wdata_o),
        .wr_o       (reg_wr_o),
        .rd_o       (reg_rd_o),
        .sdo_o      (sdo_o),
        .oe_o       (sdo_oe_o)
    );
endmodule

// File: tb/spi_regport_test.sv
module spi_regport_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic sel_n = 1'b1, sck = 1'b0, sdi = 1'b0, addr_pin = 1'b0;
    logic sdo, sdo_oe, wr, rd;
    logic [15:0] raddr, wdata, rdata;
    logic [15:0] regs [0:63];

    spi_regport uut (
        .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sck_i(sck), .sdi_i(sdi),
        .addr_pin_i(addr_pin), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
        .reg_addr_o(raddr), .reg_wdata_o(wdata), .reg_wr_o(wr), .reg_rd_o(rd),
        .reg_rdata_i(rdata)
    );

    assign rdata = regs[raddr[5:0]];
    always @(posedge clk) if (wr) regs[raddr[5:0]] <= wdata;

    int n_tests = 0, n_fail = 0;
    int wr_cnt, rd_cnt, rd_first;
    int pa, pd;
    bit oe_seen, drive_bad;
    int exp_a[$], exp_d[$];
    logic [7:0] tx [0:9];
    logic [7:0] rx [0:9];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // reference register bus model, compared on every clock
    always @(negedge clk) if (rst_n) begin
        if (wr) begin
            wr_cnt++;
            if (exp_a.size() == 0) chk(1'b0, "R6 unexpected write", int'(raddr), 0);
            else begin
                pa = exp_a.pop_front();
                pd = exp_d.pop_front();
                chk(raddr == pa[15:0] && wdata == pd[15:0], "R6/R7 write addr,data",
                    int'({raddr, wdata}), int'({pa[15:0], pd[15:0]}));
            end
        end
        if (rd) begin
            rd_cnt++;
            if (rd_first < 0) rd_first = int'(raddr);
        end
        if (sdo_oe) oe_seen = 1'b1;
    end

    task automatic hdr(input logic [6:0] dev, input logic r, input logic [15:0] sub);
        tx[0] = {dev, r};
        tx[1] = sub[15:8];
        tx[2] = sub[7:0];
    endtask

    task automatic expw(input int a, input int d);
        exp_a.push_back(a);
        exp_d.push_back(d);
    endtask

    // R3: bits driven MSB first, captured by the slave on sck rising edges
    task automatic xfer(input int nbits, input bit drive);
        oe_seen = 0; drive_bad = 0; wr_cnt = 0; rd_cnt = 0; rd_first = -1;
        sel_n = 1'b0;
        wait_clk(6);
        for (int i = 0; i < nbits; i++) begin
            sdi = tx[i / 8][7 - (i % 8)];
            wait_clk(6);
            if (i >= 24) begin
                rx[(i - 24) / 8][7 - (i % 8)] = sdo;
                if (drive && !sdo_oe) drive_bad = 1'b1;
            end else if (sdo_oe) drive_bad = 1'b1;
            sck = 1'b1;
            wait_clk(6);
            sck = 1'b0;
        end
        wait_clk(6);
        sel_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        report();
        $finish;
    end

    initial begin
        for (int k = 0; k < 64; k++) regs[k] = 16'h0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        chk(!sdo_oe && !wr && !rd, "R1 reset outputs", int'({sdo_oe, wr, rd}), 0);

        // first low pulse: a whole write, ignored
        hdr(7'd0, 1'b0, 16'h0010); tx[3] = 8'h12; tx[4] = 8'h34;
        xfer(40, 0);
        chk(wr_cnt == 0, "R1 write before mode entry", wr_cnt, 0);
        chk(regs[16] == 16'h0, "R1 register untouched", int'(regs[16]), 0);
        // second pulse
        sel_n = 1'b0; wait_clk(4); sel_n = 1'b1; wait_clk(4);
        // third pulse is itself a transfer: still ignored
        xfer(40, 0);
        chk(wr_cnt == 0, "R2 third pulse only arms", wr_cnt, 0);

        // two-location burst write
        hdr(7'd0, 1'b0, 16'h0010);
        tx[3] = 8'h12; tx[4] = 8'h34; tx[5] = 8'h56; tx[6] = 8'h78;
        expw(16'h0010, 16'h1234); expw(16'h0011, 16'h5678);
        xfer(56, 0);
        chk(wr_cnt == 2, "R2/R6 strobes after mode entry", wr_cnt, 2);
        chk(regs[16] == 16'h1234, "R5 location high byte first", int'(regs[16]), 16'h1234);
        chk(!oe_seen, "R10 write keeps output high-Z", int'(oe_seen), 0);

        // burst with carry into the high byte
        hdr(7'd0, 1'b0, 16'h00FF);
        tx[3] = 8'hAB; tx[4] = 8'hCD; tx[5] = 8'h01; tx[6] = 8'h02;
        tx[7] = 8'hFE; tx[8] = 8'hDC;
        expw(16'h00FF, 16'hABCD); expw(16'h0100, 16'h0102); expw(16'h0101, 16'hFEDC);
        xfer(72, 0);
        chk(wr_cnt == 3, "R7 burst carry count", wr_cnt, 3);

        // address mismatch, write and read
        hdr(7'd1, 1'b0, 16'h0020); tx[3] = 8'h11; tx[4] = 8'h11;
        xfer(40, 0);
        chk(wr_cnt == 0, "R4 wrong address write ignored", wr_cnt, 0);
        hdr(7'd1, 1'b1, 16'h0010);
        xfer(56, 0);
        chk(!oe_seen && rd_cnt == 0, "R4 wrong address read ignored", int'({oe_seen, rd_cnt[7:0]}), 0);

        // pin high selects address 1
        addr_pin = 1'b1;
        hdr(7'd1, 1'b0, 16'h0020); tx[3] = 8'hBE; tx[4] = 8'hEF;
        expw(16'h0020, 16'hBEEF);
        xfer(40, 0);
        chk(wr_cnt == 1, "R4 pin high matches address 1", wr_cnt, 1);
        hdr(7'd0, 1'b0, 16'h0021); tx[3] = 8'h55; tx[4] = 8'h55;
        xfer(40, 0);
        chk(wr_cnt == 0, "R4 pin high rejects address 0", wr_cnt, 0);
        addr_pin = 1'b0;

        // burst read
        hdr(7'd0, 1'b1, 16'h0010);
        xfer(56, 1);
        chk(rd_first == 16'h0010, "R8 first read location", rd_first, 16'h0010);
        chk(rd_cnt == 3, "R8 read strobes with prefetch", rd_cnt, 3);
        chk({rx[0], rx[1]} == 16'h1234, "R3/R9 first word MSB first", int'({rx[0], rx[1]}), 16'h1234);
        chk({rx[2], rx[3]} == 16'h5678, "R7/R9 second word", int'({rx[2], rx[3]}), 16'h5678);
        chk(!drive_bad, "R9/R10 drive window", int'(drive_bad), 0);
        chk(!sdo_oe, "R10 released after select high", int'(sdo_oe), 0);

        // read burst across the carry
        hdr(7'd0, 1'b1, 16'h00FF);
        xfer(56, 1);
        chk({rx[0], rx[1], rx[2], rx[3]} == 32'hABCD0102, "R7 read carry",
            int'({rx[0], rx[1], rx[2], rx[3]}), 32'hABCD0102);

        // abort partway through the second location
        hdr(7'd0, 1'b0, 16'h0030); tx[3] = 8'h77; tx[4] = 8'h88; tx[5] = 8'h99;
        expw(16'h0030, 16'h7788);
        xfer(45, 0);
        chk(wr_cnt == 1, "R11 partial location dropped", wr_cnt, 1);
        hdr(7'd0, 1'b1, 16'h0031);
        xfer(40, 1);
        chk({rx[0], rx[1]} == 16'h0000, "R11 aborted location unchanged", int'({rx[0], rx[1]}), 0);

        // abort during a read data byte
        hdr(7'd0, 1'b1, 16'h0010);
        xfer(30, 1);
        chk(!sdo_oe, "R11 output high-Z after read abort", int'(sdo_oe), 0);

        chk(exp_a.size() == 0, "R6 all expected writes seen", exp_a.size(), 0);
        report();
        $finish;
    end
endmodule